// File: doc/BRIEF.md
# Iterative Radix-4 Booth Multiplier

This block multiplies two signed 8-bit operands and returns their 16-bit two's-complement product. It does not use a single-cycle array. It recodes the multiplier operand into radix-4 Booth digits and forms one weighted partial product per iteration. A 16-bit adder adds each partial product into an accumulator. One multiplication takes four iterations.

The datapath has two registered stages. The front stage holds the operand shift registers and the digit decoder, and it registers one partial product per cycle. The back stage adds that registered partial product into the accumulator one cycle later. A small controller runs a four-phase request/complete handshake:

1. The requester raises `req`. The block accepts it only when idle.
2. The block raises `complete` when the sum is final.
3. The block holds the result until `req` falls.
4. `complete` then falls, and the block is ready for the next request.

Top module: `booth_mul_iter`

## Requirements
- R1: When `complete` is high, `product` equals the signed product of the two operands accepted with the request, taken modulo 2^16.
- R2: A zero bit is placed below bit 0 of the multiplier operand. Digit i (i = 0..3) is then taken from the padded bits {m[2i+1], m[2i], m[2i-1]}, so adjacent groups share one bit.
- R3: Each 3-bit group maps to a digit as follows: 000 and 111 give 0, 001 and 010 give +A, 011 gives +2A, 100 gives -2A, and 101 and 110 give -A. A is the sign-extended multiplicand.
- R4: Digit i is weighted by 4^i, a negative digit is added as a two's complement, and the sum wraps modulo 2^16. Example results: -128 x -128 = 16384 and -128 x 127 = -16256.
- R5: The request is accepted on a rising edge. `complete` goes high on the fifth rising edge after that edge: four partial products are decoded, and the last of the four accumulations trails the last decode by one cycle.
- R6: While `complete` and `req` are both high, `complete` stays high and `product` does not change.
- R7: One rising edge after `req` is low while `complete` is high, `complete` falls, and a new request can be accepted after that edge.
- R8: Changes on `mcand` and `mplier` after the accepting edge have no effect on the product of the operation in progress.
- R9: While reset is asserted, `complete` is 0 and `product` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request; accepted when the block is idle |
| mcand | input | 8 | Signed multiplicand |
| mplier | input | 8 | Signed multiplier operand, Booth-recoded |
| complete | output | 1 | Product valid; held until `req` falls |
| product | output | 16 | Signed product |

## Verification
The checkers assume the requester keeps `req` high from acceptance until `complete` rises. They also assume that `req` stays low for at least one cycle once it has been dropped after `complete`. The tasks in the bench raise `req` on a falling edge and hold it until `complete` is seen. They lower it only after `complete` and then wait a full cycle before the next request. Operands are driven before acceptance; they are changed only in the scenario that checks they are ignored.

// File: rtl/booth_pkg.sv
package booth_pkg;

    // Controller state
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } hs_state_e;

    // One decoded radix-4 digit: sign, magnitude 1 or magnitude 2
    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } bdigit_t;

endpackage

// File: rtl/booth_digit_dec.sv
module booth_digit_dec
    import booth_pkg::*;
(
    input  logic [2:0] grp,
    output bdigit_t    dig
);

    always_comb begin
        dig = '0;
        unique case (grp)
            3'b001, 3'b010: dig.one = 1'b1;
            3'b011:         dig.two = 1'b1;
            3'b100:         begin dig.neg = 1'b1; dig.two = 1'b1; end
            3'b101, 3'b110: begin dig.neg = 1'b1; dig.one = 1'b1; end
            default:        dig = '0;   // 000 and 111 select zero
        endcase
    end

endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
    import booth_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int CW    = 3
) (
    input  logic [WIDTH-1:0]   a,
    input  bdigit_t            dig,
    input  logic [CW-1:0]      idx,
    output logic [2*WIDTH-1:0] pp
);

    localparam int PW = 2 * WIDTH;

    logic [PW-1:0] ext;
    logic [PW-1:0] mag;
    logic [PW-1:0] shf;

    always_comb begin
        ext = {{(PW-WIDTH){a[WIDTH-1]}}, a};
        if (dig.two)
            mag = ext << 1;
        else if (dig.one)
            mag = ext;
        else
            mag = '0;
        // weight 4^idx
        shf = mag << {idx, 1'b0};
        pp  = dig.neg ? (~shf + PW'(1)) : shf;
    end

endmodule

// File: rtl/booth_hs_ctrl.sv
module booth_hs_ctrl
    import booth_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic acc_last,
    output logic start,
    output logic running,
    output logic complete
);

    hs_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req)      state_d = ST_RUN;
            ST_RUN:  if (acc_last) state_d = ST_DONE;
            ST_DONE: if (!req)     state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign start    = req && (state_q == ST_IDLE);
    assign running  = (state_q == ST_RUN);
    assign complete = (state_q == ST_DONE);

endmodule

// File: rtl/booth_mul_iter.sv
module booth_mul_iter
    import booth_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic               complete,
    output logic [2*WIDTH-1:0] product
);

    localparam int PW    = 2 * WIDTH;
    localparam int NITER = WIDTH / 2;
    localparam int CW    = $clog2(NITER + 1);

    typedef struct packed {
        logic [WIDTH-1:0] a;      // held multiplicand
        logic [WIDTH:0]   b;      // padded multiplier, shifts right by two
        logic [CW-1:0]    dcnt;   // digits issued by front stage
        logic [PW-1:0]    pp;     // registered partial product
        logic             pp_vld;
        logic [CW-1:0]    acnt;   // partial products accumulated
        logic [PW-1:0]    acc;
    } dp_t;

    dp_t     d, q;
    logic    start, running, acc_last, issue;
    bdigit_t dig;
    logic [PW-1:0] pp_w;

    booth_hs_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .acc_last (acc_last),
        .start    (start),
        .running  (running),
        .complete (complete)
    );

    booth_digit_dec u_dec (
        .grp (q.b[2:0]),
        .dig (dig)
    );

    booth_pp_gen #(.WIDTH(WIDTH), .CW(CW)) u_ppg (
        .a   (q.a),
        .dig (dig),
        .idx (q.dcnt),
        .pp  (pp_w)
    );

    assign issue    = running && (q.dcnt != CW'(NITER));
    assign acc_last = running && q.pp_vld && (q.acnt == CW'(NITER - 1));

    always_comb begin
        d = q;
        if (start) begin
            d.a      = mcand;
            d.b      = {mplier, 1'b0};
            d.dcnt   = '0;
            d.acnt   = '0;
            d.pp_vld = 1'b0;
            d.acc    = '0;
        end else if (running) begin
            // front stage: decode one digit
            d.pp_vld = issue;
            if (issue) begin
                d.pp   = pp_w;
                d.b    = q.b >> 2;
                d.dcnt = q.dcnt + CW'(1);
            end
            // back stage: accumulate previous digit
            if (q.pp_vld) begin
                d.acc  = q.acc + q.pp;
                d.acnt = q.acnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign product = q.acc;

endmodule

// File: rtl/booth_mul_iter_chk.sv
module booth_mul_iter_chk #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    input  logic               complete,
    input  logic [2*WIDTH-1:0] product,
    input  logic               start
);

    localparam int PW    = 2 * WIDTH;
    localparam int NITER = WIDTH / 2;

    logic signed [PW-1:0] exp_q;
    logic [7:0]           lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_q <= '0;
            lat_q <= '0;
        end else if (start) begin
            exp_q <= $signed(mcand) * $signed(mplier);
            lat_q <= 8'd1;
        end else if (lat_q != 8'd0 && lat_q != 8'hFF && !complete) begin
            lat_q <= lat_q + 8'd1;
        end
    end

    // R1, R4, R8: product at completion equals operands captured at start
    p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(complete) |-> (product == exp_q));

    // R5: accept edge sets lat to 1; rise seen one edge after it happens
    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(complete) |-> (lat_q == 8'(NITER + 2)));

    // R6
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (complete && req) |=> (complete && $stable(product)));

    // R7
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (complete && !req) |=> !complete);

endmodule

bind booth_mul_iter booth_mul_iter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .mcand    (mcand),
    .mplier   (mplier),
    .complete (complete),
    .product  (product),
    .start    (start)
);

// File: tb/booth_mul_iter_test.sv
`timescale 1ns/1ps
module booth_mul_iter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [7:0]  mcand = '0;
    logic [7:0]  mplier = '0;
    logic        complete;
    logic [15:0] product;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    booth_mul_iter uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .mcand    (mcand),
        .mplier   (mplier),
        .complete (complete),
        .product  (product)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        int r;
        r = $signed(a) * $signed(b);
        return r[15:0];
    endfunction

    // Raise req on a falling edge; count falling edges until complete.
    // Accept edge lies before the first counted one, so R5 gives 6.
    task automatic start_op(input logic [7:0] a, input logic [7:0] b,
                            output logic [15:0] p, output int lat);
        @(negedge clk);
        mcand = a; mplier = b; req = 1'b1; lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!complete && lat < 20);
        p = product;
    endtask

    task automatic end_op(input string rq);
        req = 1'b0;
        @(negedge clk);
        check(complete == 1'b0, rq, complete, 0);
    endtask

    task automatic one_mul(input logic [7:0] a, input logic [7:0] b, input string rq);
        logic [15:0] p;
        int lat;
        start_op(a, b, p, lat);
        check(p == ref_mul(a, b), rq, $signed(p), $signed(ref_mul(a, b)));
        end_op(rq);
    endtask

    task automatic t_reset();
        #1;
        check(complete == 1'b0, "R9 complete in reset", complete, 0);
        check(product == 16'd0, "R9 product in reset", product, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(complete == 1'b0, "R9 complete after reset", complete, 0);
    endtask

    task automatic t_corners();
        one_mul(8'h80, 8'h80, "R4 -128*-128");
        one_mul(8'h80, 8'h7F, "R4 -128*127");
        one_mul(8'h7F, 8'h80, "R4 127*-128");
        one_mul(8'h7F, 8'h7F, "R4 127*127");
        one_mul(8'hFF, 8'hFF, "R4 -1*-1");
        one_mul(8'h00, 8'h80, "R4 0*-128");
    endtask

    // low group codes via m=0..3, second group codes via m=2,6,10,14
    task automatic t_digits();
        one_mul(8'd45, 8'd0,  "R3 code 000");
        one_mul(8'd45, 8'd1,  "R3 code 010");
        one_mul(8'd45, 8'd2,  "R3 code 100/001");
        one_mul(8'd45, 8'd3,  "R3 code 110");
        one_mul(8'hB7, 8'd6,  "R3 code 011");
        one_mul(8'hB7, 8'd10, "R3 code 101");
        one_mul(8'hB7, 8'd14, "R3 code 111");
    endtask

    task automatic t_sweep();
        // every multiplicand; multiplier step 4 with offset from a: all values hit
        for (int a = 0; a < 256; a++) begin
            for (int k = 0; k < 64; k++) begin
                logic [7:0] b;
                b = 8'(4 * k + (a & 3));
                one_mul(8'(a), b, "R1 R2 sweep");
            end
        end
    endtask

    task automatic t_latency();
        logic [15:0] p;
        int lat;
        start_op(8'h93, 8'h5A, p, lat);
        check(lat == 6, "R5 latency", lat, 6);
        end_op("R5 end");
    endtask

    task automatic t_hold();
        logic [15:0] p;
        int lat;
        start_op(8'h2B, 8'hC4, p, lat);
        for (int i = 0; i < 5; i++) begin
            mcand = 8'(i * 37); mplier = 8'(i * 91);
            @(negedge clk);
            check(complete == 1'b1, "R6 complete held", complete, 1);
            check(product == p, "R6 product held", product, p);
        end
        end_op("R6 release");
    endtask

    task automatic t_release();
        logic [15:0] p;
        int lat;
        start_op(8'h11, 8'h22, p, lat);
        end_op("R7 complete falls");
        // immediate new request after the fall
        start_op(8'hF0, 8'h0F, p, lat);
        check(p == ref_mul(8'hF0, 8'h0F), "R7 next op", $signed(p), $signed(ref_mul(8'hF0, 8'h0F)));
        end_op("R7 second fall");
    endtask

    task automatic t_ignore();
        int lat;
        @(negedge clk);
        mcand = 8'h9D; mplier = 8'h63; req = 1'b1;
        @(negedge clk);          // accept edge has passed
        mcand = 8'h01; mplier = 8'h01;
        lat = 1;
        while (!complete && lat < 20) begin
            @(negedge clk);
            lat++;
            mcand = ~mcand;
        end
        check(product == ref_mul(8'h9D, 8'h63), "R8 operands ignored",
              $signed(product), $signed(ref_mul(8'h9D, 8'h63)));
        end_op("R8 end");
    endtask

    initial begin
        t_reset();
        t_latency();
        t_corners();
        t_digits();
        t_hold();
        t_release();
        t_ignore();
        t_sweep();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R5 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule